// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block sends asynchronous serial characters on a single output line. Software writes a character into a one-entry hold register through a simple strobe-and-data write port. The character moves into a frame shifter as soon as the shifter is free. The shifter then sends a complete frame: one low start bit, 5 to 9 data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. An external baud generator supplies a one-cycle `bit_tick`, and the line advances by exactly one bit per tick.

Two flags report progress. `dre` shows that the hold register can take a new character. `txc` shows that the last frame has fully left the line and nothing is waiting behind it. For 9-bit characters, the top bit comes from a separate ninth-bit register that is written first and captured together with the low byte.

When the enable is dropped, the block goes on sending until both the hold register and the shifter are empty. It then stops driving the pin and turns the pin to input, whatever direction software had selected for it.

Top module: `utx_buffered`

## Requirements
- R1: After reset, `dre`=1, `txc`=0, `txd_oe`=0 and `txd`=1.
- R2: A frame is a low start bit, the data bits with the LSB first, the parity bit if `cfg_par_en`=1, then one high stop bit, or two if `cfg_stop2`=1. Each bit is held from one `bit_tick` to the next. The line is high when idle. `cfg_size` codes 0 to 4 select 5 to 9 data bits, and codes 5 to 7 select 9 bits. The configuration is captured when a frame is loaded into the shifter.
- R3: The parity bit is the XOR of the data bits. It is inverted when `cfg_par_odd`=1, so odd parity is used; otherwise parity is even.
- R4: A `wr_data` strobe is accepted only while `dre`=1 and `tx_en`=1. Any other write is ignored and changes neither the buffered character nor the line. `dre` is 0 in the cycle after an accepted write.
- R5: The hold register moves into the shifter in the cycle after the write if the shifter is idle. Otherwise it moves at the tick that ends the last stop bit, so the next start bit follows with no idle bit in between.
- R6: `txc` sets at the tick that ends the last stop bit, but only if no character is waiting. It does not set between back-to-back frames. A `txc_clr` pulse clears it, and a set in the same cycle wins over the clear.
- R7: Data bits above the selected length are discarded and have no effect on the line, including the parity bit.
- R8: For 9-bit characters, `wr_b9` loads `b9_val` into the ninth-bit register. An accepted `wr_data` captures the ninth bit and `wr_byte` together. Later writes to the ninth-bit register do not alter a character that is already buffered.
- R9: After `tx_en` falls, pending and ongoing frames are still sent in full. One cycle after both the hold register and the shifter are empty, `txd_oe` goes to 0 and `txd` is 1.
- R10: While the transmitter is active, `txd_oe` follows `pin_dir_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable |
| pin_dir_out | input | 1 | Software pin direction, 1 = output |
| bit_tick | input | 1 | One-cycle bit-period pulse from the baud generator |
| cfg_size | input | 3 | Data length code (0..4 = 5..9 bits, 5..7 = 9 bits) |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop2 | input | 1 | 1 = two stop bits |
| wr_data | input | 1 | Write strobe for the low byte |
| wr_byte | input | 8 | Low byte of the character |
| wr_b9 | input | 1 | Write strobe for the ninth-bit register |
| b9_val | input | 1 | Ninth-bit value |
| txc_clr | input | 1 | Write-one clear of the transmit-complete flag |
| dre | output | 1 | Hold register empty |
| txc | output | 1 | Transmit complete |
| txd | output | 1 | Serial output line |
| txd_oe | output | 1 | Pin output enable |

## Verification
If the hold register's full state is wrong, the error shows on `dre` one cycle after the write. It also shows as a lost or repeated frame, or as an idle gap between back-to-back frames, which appears at the next start-bit tick. If the shifter count is wrong, the frame is too short or too long, and the decoder sees a missing stop bit or an unexpected extra start bit within one bit period of where it expects the stop bit. A wrong active state shows on `txd_oe` one cycle after the drain: the enable is either released while a frame is still on the line, or held after the block has emptied.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int DMIN = 5;
  localparam int DMAX = 9;
  localparam int BYTEW = DMAX - 1;
  localparam int FW = DMAX + 4;
  localparam int CW = $clog2(FW + 1);
  localparam int LW = $clog2(DMAX + 1);

  typedef struct packed {
    logic [2:0] size;
    logic       par_en;
    logic       par_odd;
    logic       stop2;
  } utx_cfg_t;

  function automatic logic [LW-1:0] data_len(logic [2:0] code);
    if (int'(code) > DMAX - DMIN) return LW'(DMAX);
    return LW'(DMIN) + LW'(code);
  endfunction

  function automatic logic [DMAX-1:0] trim(logic [DMAX-1:0] d, logic [LW-1:0] n);
    logic [DMAX-1:0] r;
    r = d;
    for (int i = 0; i < DMAX; i++)
      if (i >= int'(n)) r[i] = 1'b0;
    return r;
  endfunction

  function automatic logic par_bit(logic [DMAX-1:0] d, logic [LW-1:0] n, logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < DMAX; i++)
      if (i < int'(n)) p = p ^ d[i];
    return p;
  endfunction

  function automatic logic [CW-1:0] frame_len(logic [LW-1:0] n, logic pe, logic s2);
    return CW'(2 + int'(n) + int'(pe) + int'(s2));
  endfunction

  function automatic logic [FW-1:0] build_frame(logic [DMAX-1:0] d, utx_cfg_t c);
    logic [FW-1:0]   f;
    logic [LW-1:0]   n;
    logic [DMAX-1:0] m;
    n = data_len(c.size);
    m = trim(d, n);
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < DMAX; i++)
      if (i < int'(n)) f[i+1] = m[i];
    if (c.par_en) f[int'(n)+1] = par_bit(m, n, c.par_odd);
    return f;
  endfunction
endpackage

// File: rtl/utx_holdreg.sv
module utx_holdreg
  import utx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             wr_data,
  input  logic [BYTEW-1:0] wr_byte,
  input  logic             wr_b9,
  input  logic             b9_val,
  input  logic             take,
  output logic             full,
  output logic [DMAX-1:0]  word,
  output logic             wr_ok
);
  logic            full_q;
  logic            b9_q;
  logic [DMAX-1:0] buf_q;

  assign wr_ok = wr_data & tx_en & ~full_q;
  assign full  = full_q;
  assign word  = buf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      b9_q   <= 1'b0;
      buf_q  <= '0;
    end else begin
      if (wr_b9) b9_q <= b9_val;
      if (wr_ok) begin
        buf_q  <= {b9_q, wr_byte};
        full_q <= 1'b1;
      end else if (take) begin
        full_q <= 1'b0;
      end
    end
  end

  // R4 / R8: a held character is not disturbed by rejected or ninth-bit writes
  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !take) |=> $stable(buf_q));
  p_dre_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> full_q);
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
  import utx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            load,
  input  logic [DMAX-1:0] word,
  input  utx_cfg_t        cfg,
  output logic            busy,
  output logic            last,
  output logic            line
);
  logic [FW-1:0] frame_q;
  logic [CW-1:0] cnt_q;

  assign busy = (cnt_q != '0);
  assign last = busy & tick & (cnt_q == CW'(1));
  assign line = busy ? frame_q[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '1;
      cnt_q   <= '0;
    end else if (load) begin
      frame_q <= build_frame(word, cfg);
      cnt_q   <= frame_len(data_len(cfg.size), cfg.par_en, cfg.stop2);
    end else if (busy && tick) begin
      frame_q <= {1'b1, frame_q[FW-1:1]};
      cnt_q   <= cnt_q - CW'(1);
    end
  end

  // R5: a new frame enters only when the shifter is idle or finishing
  p_load_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt_q == '0 || (tick && cnt_q == CW'(1))));
  // R2: each new frame begins with a low start bit
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !line);
endmodule

// File: rtl/utx_linectl.sv
module utx_linectl (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic pin_dir_out,
  input  logic buf_full,
  input  logic busy,
  input  logic last,
  input  logic txc_clr,
  output logic txc,
  output logic oe,
  output logic act
);
  logic act_q;
  logic txc_q;
  logic txc_set_ev;

  assign txc_set_ev = last & ~buf_full;
  assign act = act_q;
  assign txc = txc_q;
  assign oe  = act_q & pin_dir_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      txc_q <= 1'b0;
    end else begin
      act_q <= tx_en | buf_full | busy;
      if (txc_set_ev)   txc_q <= 1'b1;
      else if (txc_clr) txc_q <= 1'b0;
    end
  end

  // R6: completion only after the frame has left and nothing followed it
  p_txc_after_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txc_q) |-> !busy);
  // R9: the pin is released once disabled and drained
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !buf_full && !busy) |=> !oe);
  p_busy_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> act_q);
endmodule

// File: rtl/utx_buffered.sv
module utx_buffered
  import utx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       pin_dir_out,
  input  logic       bit_tick,
  input  logic [2:0] cfg_size,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_stop2,
  input  logic       wr_data,
  input  logic [7:0] wr_byte,
  input  logic       wr_b9,
  input  logic       b9_val,
  input  logic       txc_clr,
  output logic       dre,
  output logic       txc,
  output logic       txd,
  output logic       txd_oe
);
  logic            buf_full;
  logic [DMAX-1:0] buf_word;
  logic            wr_ok;
  logic            load_ev;
  logic            busy;
  logic            last_ev;
  logic            line;
  logic            act;
  utx_cfg_t        cfg;

  assign cfg     = '{size: cfg_size, par_en: cfg_par_en, par_odd: cfg_par_odd, stop2: cfg_stop2};
  assign load_ev = buf_full & (~busy | last_ev);
  assign dre     = ~buf_full;
  assign txd     = line;

  utx_holdreg u_hold (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_data(wr_data), .wr_byte(wr_byte),
    .wr_b9(wr_b9), .b9_val(b9_val), .take(load_ev), .full(buf_full), .word(buf_word),
    .wr_ok(wr_ok)
  );

  utx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .load(load_ev), .word(buf_word),
    .cfg(cfg), .busy(busy), .last(last_ev), .line(line)
  );

  utx_linectl u_line (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .pin_dir_out(pin_dir_out),
    .buf_full(buf_full), .busy(busy), .last(last_ev), .txc_clr(txc_clr),
    .txc(txc), .oe(txd_oe), .act(act)
  );

  // R10: the pin is never driven while inactive
  p_oe_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
    txd_oe |-> act);
  // R4: a rejected write leaves the empty flag low
  p_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !wr_ok && buf_full && !load_ev) |=> !dre);
endmodule

// File: tb/utx_buffered_test.sv
module utx_buffered_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, pin_dir_out = 1'b1, bit_tick = 1'b0;
  logic [2:0] cfg_size = 3'd3;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
  logic wr_data = 1'b0, wr_b9 = 1'b0, b9_val = 1'b0, txc_clr = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic dre, txc, txd, txd_oe;
  int checks = 0;
  int fails = 0;
  bit tick_on = 1'b0;

  always #4 clk = ~clk;

  utx_buffered uut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .pin_dir_out(pin_dir_out),
    .bit_tick(bit_tick), .cfg_size(cfg_size), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2), .wr_data(wr_data),
    .wr_byte(wr_byte), .wr_b9(wr_b9), .b9_val(b9_val), .txc_clr(txc_clr),
    .dre(dre), .txc(txc), .txd(txd), .txd_oe(txd_oe)
  );

  // bit_tick: one pulse every 4 cycles, changed 1 ns after the rising edge
  initial begin
    int c;
    c = 0;
    forever begin
      @(posedge clk);
      #1;
      c = (c + 1) % 4;
      bit_tick = tick_on && (c == 3);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_par(input int d, input int n, input bit odd);
    int ones;
    ones = 0;
    for (int i = 0; i < n; i++) if (d[i]) ones++;
    return ((ones % 2) == 1) ^ odd;
  endfunction

  task automatic tick_sample(output logic v);
    do @(negedge clk); while (!bit_tick);
    v = txd;
  endtask

  // decodes one frame; checks start, parity and stop bits
  task automatic grab(input int n, input bit pe, input bit odd, input bit s2,
                      input bit imm, input string tag, output int d);
    logic v;
    int k;
    d = 0;
    tick_sample(v);
    if (imm) begin
      check(v == 1'b0, {tag, " R5 start follows stop"}, v, 0);
    end else begin
      k = 0;
      while (v !== 1'b0 && k < 40) begin tick_sample(v); k++; end
      check(v == 1'b0, {tag, " R2 start bit"}, v, 0);
    end
    for (int i = 0; i < n; i++) begin tick_sample(v); d[i] = v; end
    if (pe) begin
      tick_sample(v);
      check(v == exp_par(d, n, odd), {tag, " R3 parity"}, v, exp_par(d, n, odd));
    end
    for (int i = 0; i < 1 + int'(s2); i++) begin
      tick_sample(v);
      check(v == 1'b1, {tag, " R2 stop bit"}, v, 1);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); wr_byte = b; wr_data = 1'b1;
    @(negedge clk); wr_data = 1'b0;
  endtask

  task automatic put9(input logic b9);
    @(negedge clk); b9_val = b9; wr_b9 = 1'b1;
    @(negedge clk); wr_b9 = 1'b0;
  endtask

  task automatic wait_dre();
    while (!dre) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(dre == 1'b1, "R1 dre", dre, 1);
    check(txc == 1'b0, "R1 txc", txc, 0);
    check(txd_oe == 1'b0, "R1 oe", txd_oe, 0);
    check(txd == 1'b1, "R1 txd", txd, 1);
  endtask

  task automatic t_single();
    int d;
    cfg_size = 3'd3; cfg_par_en = 0; cfg_stop2 = 0;
    fork
      put(8'hA5);
      grab(8, 0, 0, 0, 0, "single", d);
    join
    check(d == 8'hA5, "R2 8N1 data", d, 8'hA5);
    @(negedge clk);
    check(txc == 1'b1, "R6 txc set", txc, 1);
    @(negedge clk); txc_clr = 1'b1;
    @(negedge clk); txc_clr = 1'b0;
    check(txc == 1'b0, "R6 txc cleared", txc, 0);
  endtask

  task automatic t_back2back();
    int a, b;
    logic v;
    cfg_size = 3'd3; cfg_stop2 = 1;
    fork
      begin
        put(8'h3C); wait_dre(); put(8'hC3);
        put(8'h77);
        check(dre == 1'b0, "R4 dre low while held", dre, 0);
      end
      begin
        grab(8, 0, 0, 1, 0, "b2b A", a);
        @(negedge clk);
        check(txc == 1'b0, "R6 no txc between frames", txc, 0);
        grab(8, 0, 0, 1, 1, "b2b B", b);
      end
    join
    check(a == 8'h3C, "R2 8N2 first", a, 8'h3C);
    check(b == 8'hC3, "R4 buffered byte kept", b, 8'hC3);
    @(negedge clk);
    check(txc == 1'b1, "R6 txc after last", txc, 1);
    for (int i = 0; i < 3; i++) begin
      tick_sample(v);
      check(v == 1'b1, "R4 ignored write sends nothing", v, 1);
    end
    cfg_stop2 = 0;
    txc_clr = 1'b1; @(negedge clk); txc_clr = 1'b0;
  endtask

  task automatic t_parity();
    int d;
    cfg_size = 3'd0; cfg_par_en = 1; cfg_par_odd = 0;
    fork
      put(8'hE1);
      grab(5, 1, 0, 0, 0, "5E1", d);
    join
    check(d == 8'h01, "R7 upper bits dropped", d, 8'h01);
    cfg_size = 3'd3; cfg_par_odd = 1;
    fork
      put(8'h0F);
      grab(8, 1, 1, 0, 0, "8O1", d);
    join
    check(d == 8'h0F, "R3 odd parity data", d, 8'h0F);
    cfg_par_en = 0; cfg_par_odd = 0;
  endtask

  task automatic t_nine();
    int a, b;
    cfg_size = 3'd7;
    fork
      begin
        put9(1'b0); put(8'h12); wait_dre();
        put9(1'b1); put(8'h34); put9(1'b0);
      end
      begin
        grab(9, 0, 0, 0, 0, "9N1 A", a);
        grab(9, 0, 0, 0, 1, "9N1 B", b);
      end
    join
    check(a == 9'h012, "R8 ninth bit zero", a, 9'h012);
    check(b == 9'h134, "R8 ninth bit latched", b, 9'h134);
    cfg_size = 3'd3;
  endtask

  task automatic t_disable();
    int a, b;
    fork
      begin
        put(8'h81); wait_dre(); put(8'h7E);
        @(negedge clk); tx_en = 1'b0;
      end
      begin
        grab(8, 0, 0, 0, 0, "dis A", a);
        check(txd_oe == 1'b1, "R9 oe held during drain", txd_oe, 1);
        grab(8, 0, 0, 0, 1, "dis B", b);
      end
    join
    check(b == 8'h7E, "R9 pending frame sent", b, 8'h7E);
    repeat (3) @(negedge clk);
    check(txd_oe == 1'b0, "R9 pin released", txd_oe, 0);
    check(txd == 1'b1, "R9 line high", txd, 1);
    put(8'h55);
    check(dre == 1'b1, "R4 write ignored while disabled", dre, 1);
    check(txd == 1'b1, "R4 no frame while disabled", txd, 1);
    txc_clr = 1'b1; @(negedge clk); txc_clr = 1'b0;
  endtask

  task automatic t_pindir();
    int d;
    tx_en = 1'b1; pin_dir_out = 1'b0;
    repeat (2) @(negedge clk);
    check(txd_oe == 1'b0, "R10 oe follows input dir", txd_oe, 0);
    pin_dir_out = 1'b1;
    @(negedge clk);
    check(txd_oe == 1'b1, "R10 oe follows output dir", txd_oe, 1);
    fork
      begin put(8'hC6); @(negedge clk); cfg_size = 3'd0; end
      grab(8, 0, 0, 0, 0, "latch", d);
    join
    check(d == 8'hC6, "R2 config captured at load", d, 8'hC6);
    cfg_size = 3'd3;
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    tick_on = 1'b1;
    tx_en = 1'b1;
    repeat (2) @(negedge clk);
    t_single();
    t_back2back();
    t_parity();
    t_nine();
    t_disable();
    t_pindir();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule